// File: doc/BRIEF.md
# Switchable-Depth Arithmetic Pipeline

This block is a chain of `N` arithmetic stages. Each stage has an output register. The datapath is kept simple so that results can be predicted: stage `k` (counting from 0) adds the constant `2k+1` to its input.

Every register at an odd stage index has a multiplexer that can route around it. When those multiplexers are active, the register is skipped and its stage becomes a purely combinational step. The same logic then forms either a deep pipeline of `N` registers or a shallow one of `N/2` registers. The valid bits use the same routing as the data, so the output valid always marks the true latency.

Changing depth is a request-and-drain procedure. A mode request latches the requested depth and raises `busy`. While `busy` is high, the block refuses new words. Once no word is left anywhere in the chain, the new depth takes effect and `busy` drops. The depth itself is chosen outside the block, for example by a controller that manages clock rate or power.

Top module: `alu_depth_pipe`

## Requirements
- R1: A synchronous active-high reset clears every valid bit and the pending request. It also selects deep mode, so after reset `out_valid`=0, `busy`=0, `in_ready`=1 and `shallow`=0.
- R2: In deep mode (`shallow`=0), a word accepted in cycle t appears with `out_valid`=1 in cycle t+N and in no other cycle.
- R3: In shallow mode (`shallow`=1), a word accepted in cycle t appears with `out_valid`=1 in cycle t+N/2 and in no other cycle.
- R4: The output word equals the input word plus N*N, modulo 2^W, in both modes. This is the sum of the per-stage constants 1, 3, 5, and so on.
- R5: If `mode_req`=1 is sampled while `busy`=0, `busy` is 1 from the next cycle on. `in_ready` always equals the inverse of `busy`. A word offered while `in_ready`=0 is dropped and never reaches the output.
- R6: The depth (`shallow`) changes only at the first clock edge after a request that ends a cycle with no word in flight. `busy` falls at that same edge.
- R7: `mode_sel` is captured only together with a request accepted while not busy. Toggling `mode_sel`, or raising `mode_req` again while busy, does not alter the depth that is applied.
- R8: Back-to-back words, one per cycle, leave in order, one per cycle, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_data | input | W | Input word |
| mode_sel | input | 1 | Requested depth: 1 = shallow, 0 = deep |
| mode_req | input | 1 | Depth change request |
| out_valid | output | 1 | Output word valid |
| out_data | output | W | Output word |
| busy | output | 1 | Depth change pending, pipeline draining |
| shallow | output | 1 | Current depth: 1 = shallow, 0 = deep |

## Verification
The bound checker watches the handshake on every cycle:
- `in_ready` is the inverse of `busy`.
- A request always raises `busy`.
- The depth changes only as `busy` falls.
- No output word is present in the cycle before `busy` falls.
- The reset state is correct.

Exact latency in each mode, the data transform with wraparound, and the rule that words offered while busy are dropped are left to the bench's reference model. The same applies to ignoring `mode_sel` during a drain. That model follows every accepted word to the cycle it is due.

// File: rtl/alu_depth_pipe.sv
module alu_depth_pipe #(
  parameter int W = 16,
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         mode_sel,
  input  logic         mode_req,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         busy,
  output logic         shallow
);

  logic [W-1:0] d_q [N];
  logic         v_q [N];
  logic [W-1:0] d_o [N];
  logic         v_o [N];
  logic         pend, target, idle;

  assign in_ready = ~pend;
  assign busy     = pend;

  for (genvar k = 0; k < N; k++) begin : g_stage
    logic [W-1:0] sum;
    logic         sv;
    if (k == 0) begin : g_head
      assign sum = in_data + W'(2*k+1);
      assign sv  = in_valid & ~pend;
    end else begin : g_body
      assign sum = d_o[k-1] + W'(2*k+1);
      assign sv  = v_o[k-1];
    end

    always_ff @(posedge clk) begin
      if (rst)                      v_q[k] <= 1'b0;
      else if ((k % 2 == 1) && shallow) v_q[k] <= 1'b0;
      else                          v_q[k] <= sv;
      d_q[k] <= sum;
    end

    if (k % 2 == 1) begin : g_byp
      assign d_o[k] = shallow ? sum : d_q[k];
      assign v_o[k] = shallow ? sv  : v_q[k];
    end else begin : g_fix
      assign d_o[k] = d_q[k];
      assign v_o[k] = v_q[k];
    end
  end

  always_comb begin
    idle = 1'b1;
    for (int i = 0; i < N; i++) if (v_q[i]) idle = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      target  <= 1'b0;
      shallow <= 1'b0;
    end else if (pend && idle) begin
      shallow <= target;
      pend    <= 1'b0;
    end else if (mode_req && !pend) begin
      pend   <= 1'b1;
      target <= mode_sel;
    end
  end

  assign out_valid = v_o[N-1];
  assign out_data  = d_o[N-1];

endmodule

module alu_depth_pipe_chk (
  input logic clk,
  input logic rst,
  input logic in_ready,
  input logic mode_req,
  input logic out_valid,
  input logic busy,
  input logic shallow
);

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !busy && !shallow));

  p_ready_r5: assert property (@(posedge clk) disable iff (rst)
    in_ready == !busy);

  p_busy_rise_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_req && !busy) |=> busy);

  p_mode_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(shallow) |-> ($past(busy) && !busy));

  p_drained_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !$past(out_valid));

endmodule

bind alu_depth_pipe alu_depth_pipe_chk u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .mode_req(mode_req),
  .out_valid(out_valid), .busy(busy), .shallow(shallow)
);

// File: tb/sim_alu_depth_pipe.sv
`timescale 1ns/1ps
module sim_alu_depth_pipe;
  localparam int W = 16;
  localparam int N = 10;

  logic clk = 0, rst = 1;
  logic in_valid = 0, mode_sel = 0, mode_req = 0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid, busy, shallow;
  logic [W-1:0] out_data;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  alu_depth_pipe #(.W(W), .N(N)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .mode_sel(mode_sel), .mode_req(mode_req),
    .out_valid(out_valid), .out_data(out_data), .busy(busy), .shallow(shallow));

  typedef struct { logic [W-1:0] d; int due; } item_t;
  item_t q[$];
  int  cyc = 0;
  bit  m_sh = 0, m_pend = 0, m_tgt = 0;

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_sh = 0; m_pend = 0; m_tgt = 0; cyc = 0;
    end else begin
      bit inflight, acc;
      inflight = (q.size() != 0);
      acc = in_valid && !m_pend;
      if (q.size() != 0 && q[0].due == cyc) void'(q.pop_front());
      cyc++;
      if (acc) q.push_back('{d: in_data + W'(N*N), due: cyc + (m_sh ? N/2 : N) - 1});
      if (m_pend && !inflight) begin m_sh = m_tgt; m_pend = 0; end
      else if (mode_req && !m_pend) begin m_pend = 1; m_tgt = mode_sel; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      bit ev;
      ev = (q.size() != 0) && (q[0].due == cyc);
      chk(out_valid == ev, m_sh ? "R3 out_valid" : "R2 out_valid", out_valid, ev);
      if (ev) chk(out_data == q[0].d, "R4/R8 out_data", out_data, q[0].d);
      chk(busy == m_pend, "R5 busy", busy, m_pend);
      chk(in_ready == !m_pend, "R5 in_ready", in_ready, !m_pend);
      chk(shallow == m_sh, "R6/R7 shallow", shallow, m_sh);
    end
  end

  task automatic drive(input bit v, input logic [W-1:0] d, input bit rq, input bit sel);
    @(posedge clk); #1;
    in_valid = v; in_data = d; mode_req = rq; mode_sel = sel;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) drive(0, '0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!out_valid && !busy && in_ready && !shallow, "R1 reset state",
        {out_valid, busy, in_ready, shallow}, 4'b0010);
    drive(1, 16'h0001, 0, 0); idle_n(12);                         // R2 single
    for (int i = 0; i < 15; i++) drive(1, W'(i * 37), 0, 0);       // R8 burst deep
    drive(1, 16'hFFF0, 0, 0); idle_n(3);                          // R4 wrap
    drive(1, 16'h0100, 1, 1);                                     // R5 request to shallow
    for (int i = 0; i < 14; i++) drive(1, W'(16'hA000 + i), i == 3, i % 2); // R5 dropped, R7 ignored
    idle_n(4);
    drive(1, 16'h0042, 0, 0); idle_n(8);                          // R3 single
    for (int i = 0; i < 12; i++) drive(1, W'(16'hFFE0 + i * 3), 0, 0); // R8 burst shallow, R4 wrap
    drive(0, '0, 1, 1); idle_n(5);                                // request same depth
    for (int i = 0; i < 6; i++) drive(i != 2, W'(i + 7), 0, 0);
    drive(0, '0, 1, 0); idle_n(8);                                // back to deep
    for (int i = 0; i < 200; i++) drive($urandom_range(0, 3) != 0, W'($urandom), $urandom_range(0, 40) == 0, $urandom_range(0, 1));
    idle_n(30);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule